// File: doc/BRIEF.md
# Square-Wave Flow-Control Decoder

This block sits in the transmit side of a serial link and decides whether the local sender may put data on the wire. The far receiver reports its buffer state on a back channel as a square wave. A fast wave, which changes level every cycle or every few cycles, means "ready". A slow wave, which holds each level for many cycles, means "busy". That wave comes from a clock that has no relation to the local one. The decoder therefore first retimes it through a chain of flip-flops. It then counts how many local cycles the retimed level stays unchanged and turns that run length into a single send-enable flag, which gates the transmit data path.

The decision is asymmetric. Sending stops as soon as the running count of the current level reaches the stop threshold. Sending resumes only when a whole run, closed by a level change, turned out shorter than the threshold. The edges of a slow wave therefore never let a burst slip out. A line that is stuck at one level keeps the sender halted, because the counter saturates instead of wrapping. The live count is exposed for debug.

Top module: `pace_decoder`

## Requirements
- R1: The raw back-channel bit passes through SYNC_STAGES flip-flops (default 2) before any decoding. A level captured at clock edge k first affects the counter at edge k+SYNC_STAGES.
- R2: `run_len` reports how many consecutive cycles the retimed level has been held. It becomes 1 on the edge after each detected level change and increases by one on every later edge while the level holds.
- R3: `run_len` saturates at 2^CNT_W-1 (7 by default) and stays there while the line does not change. `send_enable` remains 0 during that time.
- R4: If the line holds a new level, `send_enable` is 0 after clock edge k+SYNC_STAGES+STOP_RUN, where k is the edge that first sampled the new level. It is still 1 after the edge before that, if it was 1 before.
- R5: When a level change closes a run of 1 to STOP_RUN-1 cycles, `send_enable` is 1 after edge k+SYNC_STAGES, where k is the edge that sampled the closing change.
- R6: A run of STOP_RUN or more cycles that is closed by a level change does not set `send_enable`. A square wave with half-period STOP_RUN or more keeps `send_enable` at 0 on every cycle.
- R7: After reset, `send_enable` and `run_len` are 0. `run_len` stays 0 until the first level change of the retimed line. That first change closes no run and does not set `send_enable`.
- R8: A square wave with half-period 1 to STOP_RUN-1 cycles keeps `send_enable` at 1 on every cycle once it has been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| fc_raw | input | 1 | Back-channel square wave, asynchronous to clk |
| send_enable | output | 1 | 1 = transmit path may send, 0 = hold |
| run_len | output | CNT_W | Live count of cycles the retimed level has been held (debug) |

## Verification
The bench builds the block with SYNC_STAGES=2, STOP_RUN=4 and CNT_W=3. With these values the counter saturates at 7, only three cycles above the stop threshold. A sweep of half-periods from 1 to 9 therefore covers every short run, the exact threshold, runs between the threshold and saturation, and runs past saturation. Each half-period is swept in rising and in falling order, so it is entered once with the sender enabled and once with it halted. Single-step tests on a held level and on a two-toggle burst pin the exact edge at which the flag falls and rises.

// File: rtl/pace_pkg.sv
package pace_pkg;

  typedef enum logic {
    GATE_HALT = 1'b0,
    GATE_SEND = 1'b1
  } gate_state_t;

  // Largest value an unsigned counter of the given width can hold.
  function automatic int count_ceiling(int width);
    return (1 << width) - 1;
  endfunction

  // Next run length. 0 means no level change has been seen since reset.
  function automatic int next_run(int cur, int ceiling, bit changed);
    if (changed)          return 1;
    else if (cur == 0)    return 0;
    else if (cur >= ceiling) return ceiling;
    else                  return cur + 1;
  endfunction

  // A closed run that allows sending: at least one cycle, below threshold.
  function automatic bit run_is_short(int len, int stop_at);
    return (len >= 1) && (len < stop_at);
  endfunction

  // The live run has reached the threshold that forces a halt.
  function automatic bit run_is_long(int len, int stop_at);
    return len >= stop_at;
  endfunction

endpackage

// File: rtl/pace_sync.sv
module pace_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic synced
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= 1'b0;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign synced = stage_q[STAGES-1];

  // R1: the output follows the first stage with STAGES-1 cycles of delay.
  a_r1_chain_follows: assert property (@(posedge clk) disable iff (rst)
    $past(rst) == 1'b0 |-> (synced == $past(stage_q[STAGES-2])));
endmodule

// File: rtl/pace_runlen.sv
module pace_runlen #(
  parameter int CNT_W    = 3,
  parameter int STOP_RUN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level,
  output logic             lvl_chg,
  output logic             short_evt,
  output logic             long_hold,
  output logic [CNT_W-1:0] run_cnt
);
  import pace_pkg::*;

  localparam int CEIL = count_ceiling(CNT_W);

  logic             level_q;
  logic [CNT_W-1:0] run_cnt_d;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign lvl_chg   = level ^ level_q;
  assign run_cnt_d = CNT_W'(next_run(int'(run_cnt), CEIL, lvl_chg));
  assign short_evt = lvl_chg && run_is_short(int'(run_cnt), STOP_RUN);
  assign long_hold = run_is_long(int'(run_cnt), STOP_RUN);

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else     run_cnt <= run_cnt_d;
  end

  // R2: a detected change restarts the count at one.
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    lvl_chg |=> (run_cnt == CNT_W'(1)));
  // R3: the saturated count holds while the level is unchanged.
  a_r3_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (int'(run_cnt) == CEIL && !lvl_chg) |=> (int'(run_cnt) == CEIL));
endmodule

// File: rtl/pace_gate.sv
module pace_gate (
  input  logic clk,
  input  logic rst,
  input  logic short_evt,
  input  logic long_hold,
  output logic send_en
);
  import pace_pkg::*;

  gate_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (long_hold)      state_d = GATE_HALT;
    else if (short_evt) state_d = GATE_SEND;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= GATE_HALT;
    else     state_q <= state_d;
  end

  assign send_en = (state_q == GATE_SEND);

  // R4: a live run at the threshold forces a halt on the next edge.
  a_r4_long_halts: assert property (@(posedge clk) disable iff (rst)
    long_hold |=> !send_en);
endmodule

// File: rtl/pace_decoder.sv
module pace_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int STOP_RUN    = 4,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fc_raw,
  output logic             send_enable,
  output logic [CNT_W-1:0] run_len
);
  logic synced;
  logic lvl_chg;
  logic short_evt;
  logic long_hold;

  pace_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (fc_raw),
    .synced   (synced)
  );

  pace_runlen #(.CNT_W(CNT_W), .STOP_RUN(STOP_RUN)) u_run (
    .clk       (clk),
    .rst       (rst),
    .level     (synced),
    .lvl_chg   (lvl_chg),
    .short_evt (short_evt),
    .long_hold (long_hold),
    .run_cnt   (run_len)
  );

  pace_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .short_evt (short_evt),
    .long_hold (long_hold),
    .send_en   (send_enable)
  );

  // R5: a rise always follows a change that closed a short run.
  a_r5_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(send_enable) |-> ($past(lvl_chg) && $past(run_len) != '0
                            && int'($past(run_len)) < STOP_RUN));
  // R6: a change that closes a long run never enables.
  a_r6_long_close: assert property (@(posedge clk) disable iff (rst)
    (lvl_chg && int'(run_len) >= STOP_RUN) |=> !send_enable);
  // R7: no enable before any run has been counted.
  a_r7_idle_halt: assert property (@(posedge clk) disable iff (rst)
    (run_len == '0) |-> !send_enable);
endmodule

// File: tb/pace_decoder_test.sv
module pace_decoder_test;
  localparam int SYNC = 2;
  localparam int STOP = 4;
  localparam int CW   = 3;
  localparam int SAT  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fc_raw = 1'b0;
  logic send_enable;
  logic [CW-1:0] run_len;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pace_decoder #(.SYNC_STAGES(SYNC), .STOP_RUN(STOP), .CNT_W(CW)) uut (
    .clk         (clk),
    .rst         (rst),
    .fc_raw      (fc_raw),
    .send_enable (send_enable),
    .run_len     (run_len)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst = 1'b1;
    fc_raw = lvl;
    cyc(3);
    rst = 1'b0;
  endtask

  // Square wave with half-period hp for ten half-periods; the last four
  // half-periods form the observation window.
  task automatic sweep_one(input int hp, input string tag);
    bit en_ok = 1'b1;
    int max_run = 0;
    int exp_en = (hp < STOP) ? 1 : 0;
    int exp_max = (hp > SAT) ? SAT : hp;
    for (int h = 0; h < 10; h++) begin
      for (int c = 0; c < hp; c++) begin
        @(negedge clk);
        if (h >= 6) begin
          if (int'(send_enable) != exp_en) en_ok = 1'b0;
          if (int'(run_len) > max_run) max_run = int'(run_len);
        end
        if (c == 0) fc_raw = ~fc_raw;
      end
    end
    if (exp_en == 1) chk({"R8 steady enable ", tag}, int'(en_ok), 1);
    else             chk({"R6 steady halt ", tag}, int'(en_ok), 1);
    if (hp > SAT) chk({"R3 saturated run ", tag}, max_run, exp_max);
    else          chk({"R2 peak run ", tag}, max_run, exp_max);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    // R7: reset with the line low; it never changes.
    do_reset(1'b0);
    @(negedge clk);
    chk("R7 reset enable", int'(send_enable), 0);
    chk("R7 reset run_len", int'(run_len), 0);
    cyc(12);
    chk("R7 idle run_len stays 0", int'(run_len), 0);
    chk("R7 idle enable", int'(send_enable), 0);

    // R7/R3: reset with the line high; the retimed line makes one change.
    do_reset(1'b1);
    @(negedge clk);
    chk("R7 reset run_len high line", int'(run_len), 0);
    cyc(20);
    chk("R7 first change no enable", int'(send_enable), 0);
    chk("R3 stuck line saturates", int'(run_len), SAT);

    // R4: fast wave, then hold a level; the fall comes at edge k+SYNC+STOP.
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      fc_raw = ~fc_raw;
    end
    @(negedge clk);
    chk("R8 fast wave enables", int'(send_enable), 1);
    fc_raw = ~fc_raw;
    for (int j = 1; j <= SYNC + STOP + 2; j++) begin
      @(negedge clk);
      if (j == SYNC + STOP)     chk("R4 still sending one edge early", int'(send_enable), 1);
      if (j == SYNC + STOP + 1) chk("R4 halted on time", int'(send_enable), 0);
      if (j == SYNC + 1)        chk("R1 count starts after sync", int'(run_len), 1);
      if (j == SYNC)            chk("R1 no restart before sync", int'(run_len), 1);
    end
    cyc(10);
    chk("R3 held level stays saturated", int'(run_len), SAT);

    // R5: two toggles one cycle apart close a run of one.
    @(negedge clk);
    fc_raw = ~fc_raw;
    @(negedge clk);
    fc_raw = ~fc_raw;
    for (int m = 1; m <= SYNC + 2; m++) begin
      @(negedge clk);
      if (m == SYNC)     chk("R5 not yet enabled", int'(send_enable), 0);
      if (m == SYNC + 1) chk("R5 enabled after short run", int'(send_enable), 1);
      if (m == SYNC + 1) chk("R2 new run starts at 1", int'(run_len), 1);
      if (m == SYNC + 2) chk("R2 run counts up", int'(run_len), 2);
    end
    cyc(12);
    chk("R4 halted after burst", int'(send_enable), 0);

    // R6: a toggle that closes a long run does not enable.
    @(negedge clk);
    fc_raw = ~fc_raw;
    for (int m = 1; m <= SYNC + 3; m++) begin
      @(negedge clk);
      if (m == SYNC + 1) chk("R6 long close no enable", int'(send_enable), 0);
      if (m == SYNC + 3) chk("R6 still halted", int'(send_enable), 0);
    end

    // Sweeps of half-periods 1..9, rising then falling.
    for (int hp = 1; hp <= 9; hp++) sweep_one(hp, $sformatf("up hp=%0d", hp));
    for (int hp = 9; hp >= 1; hp--) sweep_one(hp, $sformatf("down hp=%0d", hp));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule